// File: doc/BRIEF.md
# Video Display Timing Sequencer

This block produces the raster timing and field sequencing for a video output port. A pixel counter runs across each line and a line counter runs down each field. Both advance at a selectable rate: on every clock, or on every second clock. Horizontal sync, vertical sync, field identity and an active-video flag are all decoded from the two counters. Each field has its own first active line and its own first active pixel.

Display is gated in two ways. While the blank control is high, the active flag stays low. Once blank drops, display does not begin until the next field boundary, and it begins with the first field the field-select inputs allow. When a shown field reaches its last pixel of its last line, a sticky done flag is set. The flag is one of field 1, field 2 or whole frame. Any done flag raises a combined completion flag, and that flag drives a maskable interrupt.

When continuous mode is off, the sequencer stops showing fields after one field, or after one frame in frame mode. It stays stopped until the run input is dropped and raised again.

Top module: `vdisp_seq`

## Requirements
- R1: While `run` is high, `pix_cnt` counts 0 to `cfg_width` and then returns to 0. At that wrap, `line_cnt` advances, and it returns to 0 after `cfg_height`. While `run` is low, both counters are held at 0. After reset, every output is 0.
- R2: With `pix_div2` high, the counters advance only on every second clock. With `pix_div2` low, they advance on every clock.
- R3: `hsync` is high one clock after a cycle in which `pix_cnt` is at least `hs_start` and below `hs_start + hs_len`. Otherwise it is low.
- R4: `vsync` is high one clock after a cycle in which `run` is high and `line_cnt` is 0.
- R5: `active` is high one clock after a cycle in which a field is being shown, `blank` is low, and both of these hold for the current field: `line_cnt` is at least that field's first line, and `pix_cnt` is at least that field's first pixel.
- R6: While `blank` is high, `active` stays low from the next clock on. After `blank` falls, no field is shown until the next field boundary, which is the counters wrapping from (`cfg_width`, `cfg_height`) to (0, 0).
- R7: At each field boundary the field identity toggles, starting from field 1 after reset or after `run` was low. The new field is shown only if it is selected. Outside frame mode, field 1 is selected by `f1_en` and field 2 by `f2_en`. In frame mode, showing may begin only with field 1, and field 2 then follows it.
- R8: When a shown field ends, status bits are set on the same edge at which the counters return to 0. Bit 0 is set for field 1 and bit 1 for field 2. Bit 2 is set when field 2 ends in frame mode. `sts_cmp` is the OR of the three bits.
- R9: Status bits are sticky and are cleared by a one-cycle pulse on the matching bit of `sts_clr`. If a set and a clear happen in the same cycle, the set wins.
- R10: `irq` is high one clock after a cycle in which `irq_en` and `sts_cmp` are both high, and is low otherwise.
- R11: With `cont` low, no further field is shown after the first completion, or after completion of field 2 in frame mode. This lasts until `run` has been low for at least one clock.
- R12: `field_id` reports, one clock late, the field identity of the counters: 0 for field 1, 1 for field 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables the counters and sequencing |
| blank | input | 1 | Holds the output blank |
| frame_mode | input | 1 | Shows field 1 and field 2 as one frame |
| cont | input | 1 | Continuous mode |
| f1_en | input | 1 | Selects field 1 |
| f2_en | input | 1 | Selects field 2 |
| pix_div2 | input | 1 | Advances the counters every second clock |
| cfg_width | input | CW | Last pixel index of a line |
| cfg_height | input | CW | Last line index of a field |
| hs_start | input | CW | Pixel at which horizontal sync starts |
| hs_len | input | CW | Horizontal sync width in pixel counts |
| f1_line | input | CW | First active line of field 1 |
| f1_pix | input | CW | First active pixel of field 1 |
| f2_line | input | CW | First active line of field 2 |
| f2_pix | input | CW | First active pixel of field 2 |
| irq_en | input | 1 | Interrupt enable |
| sts_clr | input | 3 | Write-one-to-clear pulses for the status bits |
| pix_cnt | output | CW | Pixel counter |
| line_cnt | output | CW | Line counter |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| field_id | output | 1 | Current field, 0 = field 1 |
| active | output | 1 | Active video |
| sts | output | 3 | Sticky done flags: field 1, field 2, frame |
| sts_cmp | output | 1 | Combined completion flag |
| irq | output | 1 | Interrupt |

## Verification
The counters and the status bits change on the same edge that samples the inputs. The sync, active and field outputs lag the counters by one clock, and `irq` lags `sts_cmp` by one clock. The bench holds its own model, driven only by the port inputs. At each rising edge the model queues the values every output must show once that edge has passed. A monitor then compares them at the following falling edge, so each result is checked in exactly the cycle it is due. Boundary-only starts, skipped fields, stopping and the half-rate mode show up as mismatches in the cycle where they first diverge.

// File: rtl/vdisp_pkg.sv
package vdisp_pkg;
  typedef enum logic { FLD_ONE = 1'b0, FLD_TWO = 1'b1 } fld_e;
  localparam int ST_F1  = 0;
  localparam int ST_F2  = 1;
  localparam int ST_FRM = 2;
  localparam int ST_W   = 3;
endpackage

// File: rtl/vdisp_rast_cnt.sv
module vdisp_rast_cnt #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          div2,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  output logic [CW-1:0] pix,
  output logic [CW-1:0] line,
  output logic          eof
);
  logic ph;
  logic tick;

  assign tick = run && (!div2 || ph);
  assign eof  = tick && (pix >= width) && (line >= height);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pix  <= '0;
      line <= '0;
      ph   <= 1'b0;
    end else begin
      ph <= div2 ? ~ph : 1'b0;
      if (tick) begin
        if (pix >= width) begin
          pix <= '0;
          if (line >= height) line <= '0;
          else                line <= line + 1'b1;
        end else begin
          pix <= pix + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vdisp_sync_gen.sv
module vdisp_sync_gen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] pix,
  input  logic [CW-1:0] line,
  input  logic [CW-1:0] hs_start,
  input  logic [CW-1:0] hs_len,
  output logic          hsync,
  output logic          vsync
);
  localparam int EW = CW + 1;
  logic [EW-1:0] hs_end;
  logic [EW-1:0] pix_x;

  assign hs_end = {1'b0, hs_start} + {1'b0, hs_len};
  assign pix_x  = {1'b0, pix};

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b0;
      vsync <= 1'b0;
    end else begin
      hsync <= run && (pix >= hs_start) && (pix_x < hs_end);
      vsync <= run && (line == '0);
    end
  end
endmodule

// File: rtl/vdisp_field_ctl.sv
module vdisp_field_ctl
  import vdisp_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            blank,
  input  logic            frame_mode,
  input  logic            cont,
  input  logic            f1_en,
  input  logic            f2_en,
  input  logic            eof,
  input  logic [CW-1:0]   pix,
  input  logic [CW-1:0]   line,
  input  logic [CW-1:0]   f1_line,
  input  logic [CW-1:0]   f1_pix,
  input  logic [CW-1:0]   f2_line,
  input  logic [CW-1:0]   f2_pix,
  output logic [ST_W-1:0] done_set,
  output logic            active,
  output logic            field_id
);
  fld_e          cur_fld;
  fld_e          nxt_fld;
  logic          shown;
  logic          stopped;
  logic          done;
  logic          stop_set;
  logic          sel_nxt;
  logic          go;
  logic [CW-1:0] first_line;
  logic [CW-1:0] first_pix;

  always_comb begin
    nxt_fld  = (cur_fld == FLD_ONE) ? FLD_TWO : FLD_ONE;
    done     = eof && shown;
    stop_set = done && !cont && (!frame_mode || cur_fld == FLD_TWO);
    if (frame_mode) sel_nxt = (nxt_fld == FLD_ONE) || shown;
    else            sel_nxt = (nxt_fld == FLD_ONE) ? f1_en : f2_en;
    go = run && !blank && !stopped && !stop_set && sel_nxt;
    done_set             = '0;
    done_set[ST_F1]      = done && (cur_fld == FLD_ONE);
    done_set[ST_F2]      = done && (cur_fld == FLD_TWO);
    done_set[ST_FRM]     = done && frame_mode && (cur_fld == FLD_TWO);
    first_line = (cur_fld == FLD_ONE) ? f1_line : f2_line;
    first_pix  = (cur_fld == FLD_ONE) ? f1_pix  : f2_pix;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cur_fld <= FLD_ONE;
      shown   <= 1'b0;
      stopped <= 1'b0;
    end else begin
      if (blank) shown <= 1'b0;
      if (eof) begin
        cur_fld <= nxt_fld;
        shown   <= go;
      end
      if (stop_set) stopped <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      field_id <= 1'b0;
    end else begin
      active   <= shown && !blank && (line >= first_line) && (pix >= first_pix);
      field_id <= (cur_fld == FLD_TWO);
    end
  end
endmodule

// File: rtl/vdisp_seq.sv
module vdisp_seq
  import vdisp_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            blank,
  input  logic            frame_mode,
  input  logic            cont,
  input  logic            f1_en,
  input  logic            f2_en,
  input  logic            pix_div2,
  input  logic [CW-1:0]   cfg_width,
  input  logic [CW-1:0]   cfg_height,
  input  logic [CW-1:0]   hs_start,
  input  logic [CW-1:0]   hs_len,
  input  logic [CW-1:0]   f1_line,
  input  logic [CW-1:0]   f1_pix,
  input  logic [CW-1:0]   f2_line,
  input  logic [CW-1:0]   f2_pix,
  input  logic            irq_en,
  input  logic [ST_W-1:0] sts_clr,
  output logic [CW-1:0]   pix_cnt,
  output logic [CW-1:0]   line_cnt,
  output logic            hsync,
  output logic            vsync,
  output logic            field_id,
  output logic            active,
  output logic [ST_W-1:0] sts,
  output logic            sts_cmp,
  output logic            irq
);
  logic            eof;
  logic [ST_W-1:0] done_set;

  vdisp_rast_cnt #(.CW(CW)) cnt_i (
    .clk(clk), .rst(rst), .run(run), .div2(pix_div2),
    .width(cfg_width), .height(cfg_height),
    .pix(pix_cnt), .line(line_cnt), .eof(eof)
  );

  vdisp_sync_gen #(.CW(CW)) sync_i (
    .clk(clk), .rst(rst), .run(run), .pix(pix_cnt), .line(line_cnt),
    .hs_start(hs_start), .hs_len(hs_len), .hsync(hsync), .vsync(vsync)
  );

  vdisp_field_ctl #(.CW(CW)) fld_i (
    .clk(clk), .rst(rst), .run(run), .blank(blank),
    .frame_mode(frame_mode), .cont(cont), .f1_en(f1_en), .f2_en(f2_en),
    .eof(eof), .pix(pix_cnt), .line(line_cnt),
    .f1_line(f1_line), .f1_pix(f1_pix), .f2_line(f2_line), .f2_pix(f2_pix),
    .done_set(done_set), .active(active), .field_id(field_id)
  );

  for (genvar gi = 0; gi < ST_W; gi++) begin : g_sts
    always_ff @(posedge clk) begin
      if (rst)                  sts[gi] <= 1'b0;
      else if (done_set[gi])    sts[gi] <= 1'b1;
      else if (sts_clr[gi])     sts[gi] <= 1'b0;
    end
  end

  assign sts_cmp = |sts;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_en && sts_cmp;
  end
endmodule

// File: rtl/vdisp_seq_chk.sv
module vdisp_seq_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          blank,
  input logic          irq_en,
  input logic [2:0]    sts_clr,
  input logic [CW-1:0] cfg_width,
  input logic [CW-1:0] pix_cnt,
  input logic [CW-1:0] line_cnt,
  input logic          active,
  input logic [2:0]    sts,
  input logic          sts_cmp,
  input logic          irq
);
  logic pv;
  always_ff @(posedge clk) pv <= !rst;

  p_pix_range_r1: assert property (@(posedge clk) disable iff (rst || !pv)
    $stable(cfg_width) |-> pix_cnt <= cfg_width);

  p_blank_holds_r6: assert property (@(posedge clk) disable iff (rst || !pv)
    $past(blank) |-> !active);

  p_set_at_wrap_r8: assert property (@(posedge clk) disable iff (rst || !pv)
    $rose(sts_cmp) |-> (pix_cnt == '0 && line_cnt == '0));

  for (genvar gi = 0; gi < 3; gi++) begin : g_sticky
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst || !pv)
      ($past(sts[gi]) && !$past(sts_clr[gi])) |-> sts[gi]);
  end

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst || !pv)
    irq |-> ($past(irq_en) && $past(sts_cmp)));

  p_irq_due_r10: assert property (@(posedge clk) disable iff (rst || !pv)
    ($past(irq_en) && $past(sts_cmp)) |-> irq);
endmodule

bind vdisp_seq vdisp_seq_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst(rst), .blank(blank), .irq_en(irq_en), .sts_clr(sts_clr),
  .cfg_width(cfg_width), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
  .active(active), .sts(sts), .sts_cmp(sts_cmp), .irq(irq)
);

// File: tb/vdisp_seq_tb_top.sv
module vdisp_seq_tb_top;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 0, blank = 1, frame_mode = 0, cont = 1, f1_en = 1, f2_en = 1, pix_div2 = 0;
  logic [CW-1:0] cfg_width = 15, cfg_height = 7, hs_start = 3, hs_len = 4;
  logic [CW-1:0] f1_line = 2, f1_pix = 4, f2_line = 3, f2_pix = 6;
  logic irq_en = 0;
  logic [2:0] sts_clr = '0;
  logic [CW-1:0] pix_cnt, line_cnt;
  logic hsync, vsync, field_id, active, sts_cmp, irq;
  logic [2:0] sts;

  always #10 clk = ~clk;

  vdisp_seq #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .run(run), .blank(blank), .frame_mode(frame_mode),
    .cont(cont), .f1_en(f1_en), .f2_en(f2_en), .pix_div2(pix_div2),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .hs_start(hs_start),
    .hs_len(hs_len), .f1_line(f1_line), .f1_pix(f1_pix), .f2_line(f2_line),
    .f2_pix(f2_pix), .irq_en(irq_en), .sts_clr(sts_clr), .pix_cnt(pix_cnt),
    .line_cnt(line_cnt), .hsync(hsync), .vsync(vsync), .field_id(field_id),
    .active(active), .sts(sts), .sts_cmp(sts_cmp), .irq(irq)
  );

  typedef struct {
    int pix; int line; bit hs; bit vs; bit act; bit fid; bit [2:0] st; bit irq;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done_run = 0;

  task automatic chk(string tag, int act_v, int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act_v, exp_v, cyc);
    end
  endtask

  // reference model, from the requirements, driven only by the inputs
  int m_pix = 0, m_line = 0;
  bit m_ph = 0, m_fld = 0, m_shown = 0, m_stop = 0, m_irq = 0;
  bit [2:0] m_sts = '0;
  bit m_hs = 0, m_vs = 0, m_act = 0, m_fid = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_pix = 0; m_line = 0; m_ph = 0; m_fld = 0; m_shown = 0; m_stop = 0;
      m_sts = '0; m_irq = 0; m_hs = 0; m_vs = 0; m_act = 0; m_fid = 0;
    end else begin
      bit tick, eof, done, stop_set, nxt, sel, go;
      bit [2:0] set;
      int fl, fp;
      tick = run && (!pix_div2 || m_ph);
      eof  = tick && m_pix == cfg_width && m_line == cfg_height;
      done = eof && m_shown;
      stop_set = done && !cont && (!frame_mode || m_fld);
      nxt = ~m_fld;
      sel = frame_mode ? (!nxt || m_shown) : (nxt ? f2_en : f1_en);
      go  = run && !blank && !m_stop && !stop_set && sel;
      set = {done && frame_mode && m_fld, done && m_fld, done && !m_fld};
      fl = m_fld ? f2_line : f1_line;
      fp = m_fld ? f2_pix : f1_pix;
      m_hs  = run && m_pix >= hs_start && m_pix < hs_start + hs_len;
      m_vs  = run && m_line == 0;
      m_act = m_shown && !blank && m_line >= fl && m_pix >= fp;
      m_fid = m_fld;
      m_irq = irq_en && (m_sts != 0);
      m_sts = set | (m_sts & ~sts_clr);
      if (!run) begin
        m_pix = 0; m_line = 0; m_ph = 0; m_fld = 0; m_shown = 0; m_stop = 0;
      end else begin
        m_ph = pix_div2 ? ~m_ph : 1'b0;
        if (tick) begin
          if (m_pix == cfg_width) begin
            m_pix = 0;
            m_line = (m_line == cfg_height) ? 0 : m_line + 1;
          end else m_pix++;
        end
        if (blank) m_shown = 0;
        if (eof) begin m_fld = nxt; m_shown = go; end
        if (stop_set) m_stop = 1;
      end
    end
    q.push_back('{m_pix, m_line, m_hs, m_vs, m_act, m_fid, m_sts, m_irq});
  end

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(pix_div2 ? "R2 pix_cnt" : "R1 pix_cnt", pix_cnt, e.pix);
      chk(pix_div2 ? "R2 line_cnt" : "R1 line_cnt", line_cnt, e.line);
      chk("R3 hsync", hsync, e.hs);
      chk("R4 vsync", vsync, e.vs);
      chk("R5/R6/R7/R11 active", active, e.act);
      chk("R12 field_id", field_id, e.fid);
      chk("R8/R9 sts", sts, e.st);
      chk("R8 sts_cmp", sts_cmp, e.st != 0);
      chk("R10 irq", irq, e.irq);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(bit [2:0] m);
    sts_clr = m; wait_cyc(1); sts_clr = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wait_cyc(3);
    // R1: reset state
    chk("R1 reset pix", pix_cnt, 0); chk("R1 reset irq", irq, 0);
    chk("R1 reset sts", sts, 0);     chk("R1 reset active", active, 0);
    rst = 0;
    // R6: blanked run, sync outputs alive
    run = 1; wait_cyc(300);
    // R6: blank falls mid-field, display waits for the boundary
    blank = 0; wait_cyc(600);
    // R10: interrupt enabled, then cleared by R9 pulse
    irq_en = 1; wait_cyc(50); pulse_clr(3'b111); wait_cyc(200);
    // R7/R11: only field 2 selected, single shot
    run = 0; wait_cyc(2); pulse_clr(3'b111);
    f1_en = 0; f2_en = 1; cont = 0; run = 1; wait_cyc(700);
    // R8/R11: frame mode, single frame
    run = 0; frame_mode = 1; f1_en = 0; f2_en = 0; pulse_clr(3'b111);
    run = 1; wait_cyc(900);
    // R2: half-rate counting, continuous
    run = 0; frame_mode = 0; f1_en = 1; f2_en = 0; cont = 1; pix_div2 = 1;
    pulse_clr(3'b111); run = 1; wait_cyc(800);
    // R6: blank again while showing
    blank = 1; wait_cyc(100); blank = 0; wait_cyc(400);
    done_run = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule